// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the 64-bit privileged control registers of a processor core and serves them through a single index-addressed port. A request presents an index together with a write strobe, a read strobe or both. A write stores only the bits that the addressed register's own mask permits. Two registers discard the write data and clear to zero instead. One register, when read, returns a live count in its low half. A read returns its data on the clock edge after the request.

Requests that the map does not allow are refused. These are a write to a read-only register, a read of a write-only register, an access to an unassigned index, and a repeated write to the write-once counter-control register. A refused request changes no state, forces the read data to zero and raises a one-cycle error pulse. Two decoded levels go straight to neighbouring logic: the interrupt priority level and the current processor mode. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset every register reads zero except three. The trap base register (index 32) holds the BASE_RST parameter, the machine control register (index 48) holds 0x6, and scratch register 16 holds the zero-extended `cpu_id`. `ipl_level`, `proc_mode`, `err` and `rd_data` are zero.
- R2: An accepted read at index i updates `rd_data` to register i's value one clock edge later. `rd_data` holds its value while no read is requested. A read and a write in the same request return the value from before the write.
- R3: Writes keep only these masked bits:
  - scratch 0..23, trap base (32), machine control (48) and counter (49): all bits.
  - AST request (34) and AST enable (35): 0xF.
  - interrupt priority level (36): 0x1F.
  - current mode (37) and data mode (38): 0x18.
  - software interrupt request (39): 0x7FFF0.
  - interrupt control (40): 0xFF_FFFF_0300.
  - page-table base (41): 0xFFFF_FFFF_C000_0000.
  - cache mode (42) and miss mode (43): 0x3F.
  - instruction ASN (44): 0x7F0.
  - data ASN (45): 0xFE00_0000_0000_0000.
- R4: A write to the exception address register (index 33) always stores bit 1 as zero.
- R5: Any write to the exception summary (46) or exception mask (47) register leaves it zero, whatever the write data.
- R6: A read of the counter register (49) returns the stored bits 63:32 in the high half. The low half holds the low 32 bits of a free-running cycle counter that advances by one per clock.
- R7: An error is flagged for each of these requests:
  - a write to the read-only interrupt id register (51), which reads zero;
  - a read of the write-only counter control (50) or interrupt clear (52) registers;
  - any access to indices 24..31 or 53..63.
- R8: A refused request has no effect on any register. `rd_data` becomes zero and `err` is high for exactly the one cycle after that request.
- R9: The counter control register (50) accepts one write after reset. Every later write to it is refused as an error.
- R10: `ipl_level` shows bits 4:0 of register 36, and `proc_mode` shows bits 4:3 of register 37. Both update on the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cpu_id | input | CPU_ID_W | Core number, loaded into scratch 16 at reset |
| idx | input | 6 | Register index |
| wr_en | input | 1 | Write request |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 64 | Registered read data |
| err | output | 1 | One-cycle error pulse |
| ipl_level | output | 5 | Current interrupt priority level |
| proc_mode | output | 2 | Current processor mode |

## Verification
The in-RTL assertions watch, on every cycle, these invariants:
- a forbidden bit never reaches the priority-level or exception-address registers;
- write-to-clear registers stay zero after a write;
- unassigned indices and a repeated counter-control write always produce the error;
- an error cycle always carries zero read data;
- the cycle counter steps by exactly one.

Only the bench scenarios can show the rest:
- the exact value each mask leaves for chosen data;
- the reset defaults;
- read-before-write ordering and holding of `rd_data`;
- the composed counter read, whose low half must advance by the elapsed cycle count between two reads.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  localparam int DATA_W    = 64;
  localparam int IDX_W     = 6;
  localparam int NUM_IDX   = 1 << IDX_W;
  localparam int SCRATCH_N = 24;
  localparam int SCR_CPU   = 16;

  localparam logic [IDX_W-1:0] IX_TRAP_BASE = 6'd32;
  localparam logic [IDX_W-1:0] IX_EXC_ADDR  = 6'd33;
  localparam logic [IDX_W-1:0] IX_AST_REQ   = 6'd34;
  localparam logic [IDX_W-1:0] IX_AST_EN    = 6'd35;
  localparam logic [IDX_W-1:0] IX_IPL       = 6'd36;
  localparam logic [IDX_W-1:0] IX_CUR_MODE  = 6'd37;
  localparam logic [IDX_W-1:0] IX_DAT_MODE  = 6'd38;
  localparam logic [IDX_W-1:0] IX_SW_INT    = 6'd39;
  localparam logic [IDX_W-1:0] IX_INT_CTL   = 6'd40;
  localparam logic [IDX_W-1:0] IX_PT_BASE   = 6'd41;
  localparam logic [IDX_W-1:0] IX_CACHE_MD  = 6'd42;
  localparam logic [IDX_W-1:0] IX_MISS_MD   = 6'd43;
  localparam logic [IDX_W-1:0] IX_I_ASN     = 6'd44;
  localparam logic [IDX_W-1:0] IX_D_ASN     = 6'd45;
  localparam logic [IDX_W-1:0] IX_EXC_SUM   = 6'd46;
  localparam logic [IDX_W-1:0] IX_EXC_MASK  = 6'd47;
  localparam logic [IDX_W-1:0] IX_MCTL      = 6'd48;
  localparam logic [IDX_W-1:0] IX_CYC_CNT   = 6'd49;
  localparam logic [IDX_W-1:0] IX_CYC_CTL   = 6'd50;
  localparam logic [IDX_W-1:0] IX_INT_ID    = 6'd51;
  localparam logic [IDX_W-1:0] IX_HW_CLR    = 6'd52;

  typedef struct packed {
    logic              valid;
    logic              rd_ok;
    logic              wr_ok;
    logic              clr_on_wr;
    logic [DATA_W-1:0] wmask;
  } reg_attr_t;

  // Access rights and write mask of one index.
  function automatic reg_attr_t reg_attr(input logic [IDX_W-1:0] ix);
    reg_attr_t a;
    a.valid     = 1'b1;
    a.rd_ok     = 1'b1;
    a.wr_ok     = 1'b1;
    a.clr_on_wr = 1'b0;
    a.wmask     = '1;
    if (int'(ix) >= SCRATCH_N) begin
      case (ix)
        IX_TRAP_BASE, IX_MCTL, IX_CYC_CNT: ;
        IX_EXC_ADDR:              a.wmask = ~64'h2;
        IX_AST_REQ, IX_AST_EN:    a.wmask = 64'hF;
        IX_IPL:                   a.wmask = 64'h1F;
        IX_CUR_MODE, IX_DAT_MODE: a.wmask = 64'h18;
        IX_SW_INT:                a.wmask = 64'h7_FFF0;
        IX_INT_CTL:               a.wmask = 64'hFF_FFFF_0300;
        IX_PT_BASE:               a.wmask = 64'hFFFF_FFFF_C000_0000;
        IX_CACHE_MD, IX_MISS_MD:  a.wmask = 64'h3F;
        IX_I_ASN:                 a.wmask = 64'h7F0;
        IX_D_ASN:                 a.wmask = 64'hFE00_0000_0000_0000;
        IX_EXC_SUM, IX_EXC_MASK: begin
          a.clr_on_wr = 1'b1;
          a.wmask     = '0;
        end
        IX_CYC_CTL, IX_HW_CLR:    a.rd_ok = 1'b0;
        IX_INT_ID:                a.wr_ok = 1'b0;
        default:                  a = '0;
      endcase
    end
    return a;
  endfunction
endpackage

// File: rtl/ctrl_reg_rst_sync.sv
module ctrl_reg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ctrl_reg_cyc_ctr.sv
module ctrl_reg_cyc_ctr #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CTR_W-1:0] count
);
  logic [CTR_W-1:0] count_d;

  always_comb count_d = count + CTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  // R6
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> count == $past(count) + CTR_W'(1));
endmodule

// File: rtl/ctrl_reg_store.sv
module ctrl_reg_store
  import ctrl_reg_pkg::*;
#(
  parameter int                CPU_ID_W = 8,
  parameter logic [DATA_W-1:0] BASE_RST = 64'h0000_0000_0000_8000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_ID_W-1:0] cpu_id,
  input  logic                wr_fire,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   regs_o [NUM_IDX]
);
  for (genvar i = 0; i < NUM_IDX; i++) begin : g_ent
    localparam reg_attr_t A = reg_attr(IDX_W'(i));
    if (A.rd_ok && A.wr_ok) begin : g_ff
      logic [DATA_W-1:0] q, d, rv;
      logic              we;

      always_comb begin
        we = wr_fire && (wr_idx == IDX_W'(i));
        d  = A.clr_on_wr ? '0 : (wr_data & A.wmask);
        if (i == int'(IX_TRAP_BASE))  rv = BASE_RST;
        else if (i == int'(IX_MCTL))  rv = DATA_W'(6);
        else if (i == SCR_CPU)        rv = DATA_W'(cpu_id);
        else                          rv = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= rv;
        else if (we) q <= d;
      end

      assign regs_o[i] = q;
    end else begin : g_const
      assign regs_o[i] = '0;
    end
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrl_reg_pkg::*;
#(
  parameter int                CPU_ID_W = 8,
  parameter int                CTR_W    = 32,
  parameter logic [DATA_W-1:0] BASE_RST = 64'h0000_0000_0000_8000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_ID_W-1:0] cpu_id,
  input  logic [IDX_W-1:0]    idx,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  output logic                err,
  output logic [4:0]          ipl_level,
  output logic [1:0]          proc_mode
);
  localparam int HALF_W = DATA_W / 2;

  logic              rst_sync_n;
  logic [CTR_W-1:0]  cyc_count;
  logic [DATA_W-1:0] regs [NUM_IDX];
  reg_attr_t         attr;
  logic              cyc_done, cyc_done_d;
  logic              rd_bad, wr_bad, acc_err, wr_fire;
  logic              rd_data_en;
  logic [DATA_W-1:0] rd_val, rd_data_d;

  ctrl_reg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ctrl_reg_cyc_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .count (cyc_count)
  );

  ctrl_reg_store #(.CPU_ID_W(CPU_ID_W), .BASE_RST(BASE_RST)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cpu_id  (cpu_id),
    .wr_fire (wr_fire),
    .wr_idx  (idx),
    .wr_data (wr_data),
    .regs_o  (regs)
  );

  // Decode and access check
  always_comb begin
    attr       = reg_attr(idx);
    rd_bad     = rd_en && !attr.rd_ok;
    wr_bad     = wr_en && (!attr.wr_ok || (idx == IX_CYC_CTL && cyc_done));
    acc_err    = rd_bad || wr_bad;
    wr_fire    = wr_en && !acc_err;
    cyc_done_d = cyc_done || (wr_fire && idx == IX_CYC_CTL);
    if (idx == IX_CYC_CNT)
      rd_val = {regs[IX_CYC_CNT][DATA_W-1:HALF_W], HALF_W'(cyc_count)};
    else
      rd_val = regs[idx];
    rd_data_en = rd_en || acc_err;
    rd_data_d  = acc_err ? '0 : rd_val;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data  <= '0;
      err      <= 1'b0;
      cyc_done <= 1'b0;
    end else begin
      err      <= acc_err;
      cyc_done <= cyc_done_d;
      if (rd_data_en) rd_data <= rd_data_d;
    end
  end

  assign ipl_level = regs[IX_IPL][4:0];
  assign proc_mode = regs[IX_CUR_MODE][4:3];

  // R8
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err |-> rd_data == '0);
  // R7
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((rd_en || wr_en) && ((idx >= IDX_W'(SCRATCH_N) && idx < IX_TRAP_BASE) || idx > IX_HW_CLR))
      |=> err);
  // R7
  decode_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((rd_en || wr_en) && !attr.valid) |=> err);
  // R9
  cyc_ctl_once_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && idx == IX_CYC_CTL && cyc_done) |=> err);
  // R4
  exc_addr_bit1_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    regs[IX_EXC_ADDR][1] == 1'b0);
  // R3
  ipl_width_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    regs[IX_IPL][DATA_W-1:5] == '0);
  // R5
  clr_on_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (idx == IX_EXC_SUM || idx == IX_EXC_MASK)) |=>
      (regs[IX_EXC_SUM] == '0 && regs[IX_EXC_MASK] == '0));
endmodule

// File: tb/ctrl_reg_bank_tb.sv
`timescale 1ns/1ps
module ctrl_reg_bank_tb_top;
  localparam logic [63:0] BASE_V = 64'h0000_0000_2000_4000;
  localparam logic [7:0]  CPU_V  = 8'h5A;

  typedef struct packed {
    logic [5:0]  ix;
    logic [63:0] wd;
    logic [63:0] ex;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam vec_t VECS [19] = '{
    '{6'd5,  64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0},
    '{6'd23, 64'h5555_AAAA_5555_AAAA, 64'h5555_AAAA_5555_AAAA},
    '{6'd32, ONES, ONES},
    '{6'd33, ONES, 64'hFFFF_FFFF_FFFF_FFFD},
    '{6'd34, ONES, 64'hF},
    '{6'd35, ONES, 64'hF},
    '{6'd36, ONES, 64'h1F},
    '{6'd37, ONES, 64'h18},
    '{6'd38, ONES, 64'h18},
    '{6'd39, 64'h12345, 64'h12340},
    '{6'd40, 64'h12_3456_7890, 64'h12_3456_0000},
    '{6'd41, ONES, 64'hFFFF_FFFF_C000_0000},
    '{6'd42, ONES, 64'h3F},
    '{6'd43, ONES, 64'h3F},
    '{6'd44, ONES, 64'h7F0},
    '{6'd45, ONES, 64'hFE00_0000_0000_0000},
    '{6'd46, ONES, 64'h0},
    '{6'd47, ONES, 64'h0},
    '{6'd48, 64'hAAAA, 64'hAAAA}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  idx;
  logic        wr_en, rd_en;
  logic [63:0] wr_data, rd_data;
  logic        err;
  logic [4:0]  ipl_level;
  logic [1:0]  proc_mode;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ctrl_reg_bank #(.CPU_ID_W(8), .CTR_W(32), .BASE_RST(BASE_V)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_id(CPU_V), .idx(idx),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .err(err), .ipl_level(ipl_level), .proc_mode(proc_mode)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request after a negedge; outputs are valid at the next negedge.
  task automatic acc(input logic r, input logic w, input logic [5:0] i, input logic [63:0] d);
    rd_en = r; wr_en = w; idx = i; wr_data = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] c0, c1;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; idx = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 err", 64'(err), 64'h0);
    chk("R1 rd_data", rd_data, 64'h0);
    chk("R1 ipl_level", 64'(ipl_level), 64'h0);
    chk("R1 proc_mode", 64'(proc_mode), 64'h0);
    acc(1, 0, 6'd32, 0); chk("R1 trap base", rd_data, BASE_V);
    acc(1, 0, 6'd48, 0); chk("R1 machine ctl", rd_data, 64'h6);
    acc(1, 0, 6'd16, 0); chk("R1 scratch16 cpu id", rd_data, 64'h5A);
    acc(1, 0, 6'd0,  0); chk("R1 scratch0", rd_data, 64'h0);
    acc(1, 0, 6'd36, 0); chk("R1 ipl reg", rd_data, 64'h0);

    // R3 R4 R5 masked writes from table
    foreach (VECS[k]) begin
      acc(0, 1, VECS[k].ix, VECS[k].wd);
      chk("R3 write no err", 64'(err), 64'h0);
      acc(1, 0, VECS[k].ix, 0);
      chk("R3 R4 R5 masked readback", rd_data, VECS[k].ex);
    end

    // R10 decoded outputs (table left ipl=1F, mode=18)
    chk("R10 ipl after table", 64'(ipl_level), 64'h1F);
    chk("R10 mode after table", 64'(proc_mode), 64'h3);
    acc(0, 1, 6'd36, 64'hFFFF_FFE7);
    chk("R10 ipl next edge", 64'(ipl_level), 64'h07);
    acc(0, 1, 6'd37, 64'h08);
    chk("R10 mode next edge", 64'(proc_mode), 64'h1);

    // R4 exc address bit 1
    acc(0, 1, 6'd33, 64'h2);
    acc(1, 0, 6'd33, 0); chk("R4 bit1 cleared", rd_data, 64'h0);

    // R2 hold and read-before-write
    acc(1, 0, 6'd5, 0);
    @(negedge clk);
    chk("R2 hold when idle", rd_data, 64'h1234_5678_9ABC_DEF0);
    acc(1, 1, 6'd5, 64'hCAFE);
    chk("R2 read returns old", rd_data, 64'h1234_5678_9ABC_DEF0);
    acc(1, 0, 6'd5, 0); chk("R2 new value", rd_data, 64'hCAFE);

    // R7 R8 errors
    acc(0, 1, 6'd51, ONES); chk("R7 write read-only err", 64'(err), 64'h1);
    chk("R8 rd_data zero on err", rd_data, 64'h0);
    @(negedge clk); chk("R8 err one cycle", 64'(err), 64'h0);
    acc(1, 0, 6'd51, 0);
    chk("R7 read-only readable", 64'(err), 64'h0);
    chk("R8 read-only unchanged", rd_data, 64'h0);
    acc(1, 0, 6'd52, 0); chk("R7 read write-only clr err", 64'(err), 64'h1);
    acc(1, 0, 6'd50, 0); chk("R7 read write-only ctl err", 64'(err), 64'h1);
    acc(1, 0, 6'd24, 0); chk("R7 idx24 err", 64'(err), 64'h1);
    acc(0, 1, 6'd63, 1); chk("R7 idx63 err", 64'(err), 64'h1);
    acc(1, 0, 6'd5, 0);  chk("R8 prior read", rd_data, 64'hCAFE);
    acc(1, 0, 6'd30, 0); chk("R8 err zeroes rd_data", rd_data, 64'h0);
    acc(1, 1, 6'd52, 64'hFF);
    chk("R8 combined err", 64'(err), 64'h1);

    // R9 write-once control
    acc(0, 1, 6'd50, 1); chk("R9 first write ok", 64'(err), 64'h0);
    acc(0, 1, 6'd50, 1); chk("R9 second write err", 64'(err), 64'h1);

    // R6 live counter read
    acc(0, 1, 6'd49, 64'hDEAD_BEEF_1111_2222);
    acc(1, 0, 6'd49, 0); c0 = rd_data;
    repeat (9) @(negedge clk);
    acc(1, 0, 6'd49, 0); c1 = rd_data;
    chk("R6 high half stored", 64'(c1[63:32]), 64'hDEAD_BEEF);
    chk("R6 low half advances", 64'(c1[31:0] - c0[31:0]), 64'd10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule